// File: doc/BRIEF.md
# Serial Flash Status Register Write Guard

This block keeps the 16-bit status register of a serial flash device and decides when that register may be written. The instruction decoder hands it one strobe per completed instruction, together with the opcode and the 16-bit data that was shifted in. The block also takes the level of the active-low write-protect pin. A separate strobe marks an ordinary supply cycle, and another marks the very first power-up, which loads the factory state.

Write permission depends on a two-bit protection mode and the pin level. One mode follows the pin. One mode blocks writes until the next supply cycle and then clears itself. One mode freezes the register for good. The four security-register lock bits can only ever go from 0 to 1. The complement-protect bit goes out to the array protection decode. The suspend flag is changed only by its own opcodes and by a supply cycle.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset, or after an init strobe, the status word, the lock vector, `cmp_o` and `sr_wr_ok_o` are all 0. Bit 0 of the status word is always 0.
- R2: Opcode 06h sets the write-enable latch (status bit 1) and opcode 04h clears it. In mode 00 (bits 8,7 of the status word) `sr_wr_ok_o` equals the latch, whatever the pin level.
- R3: In mode 01, a low write-protect pin forces `sr_wr_ok_o` to 0. With a high pin, `sr_wr_ok_o` follows the write-enable latch.
- R4: In mode 10, status writes are refused. A supply-cycle strobe returns the mode to 00 and keeps every other non-volatile bit.
- R5: In mode 11, no status write is ever accepted, and the mode survives a supply cycle. Bits 14 to 2 change only through an init strobe.
- R6: Bits 13 to 10 are lock bits. Bit 10+i locks security register i, and `sec_lock_o[i]` mirrors it. An accepted write sets each lock bit where the data has a 1. A 0 in the data never clears a lock bit, and neither does a supply cycle.
- R7: Bit 15 is the suspend flag. Opcode 75h sets it. Opcode 7Ah or a supply cycle clears it. A status write never changes it.
- R8: Opcode 01h is the status write. When it is accepted, it loads bits 14 to 2 from the data (lock bits follow R6). When it is refused, those bits stay unchanged. In both cases the write-enable latch is 0 afterwards.
- R9: A supply-cycle strobe clears the write-enable latch and the suspend flag, and keeps bits 14 to 2 except as R4 says.
- R10: Bit 14 is the complement-protect bit. An accepted write sets it, it survives a supply cycle, and `cmp_o` mirrors it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, loads factory state |
| instr_valid | input | 1 | One-cycle strobe: a decoded instruction has completed |
| instr_op | input | 8 | Opcode of the completed instruction |
| wr_data | input | 16 | Data word of a status write |
| wp_pin_high | input | 1 | Level of the active-low write-protect pin (1 = high) |
| pwr_cycle | input | 1 | Strobe: supply went down and came back |
| nv_init | input | 1 | Strobe: first power-up, load factory defaults |
| status_o | output | 16 | Current status word |
| sr_wr_ok_o | output | 1 | A status write issued now would be accepted |
| sec_lock_o | output | 4 | Read-only flag for each security register |
| cmp_o | output | 1 | Complement-protect bit for the array decode |

## Verification
The bench tries a status write while the pin is low in mode 00, where a design that wrongly used the pin would refuse it. It tries the same write in mode 01, where a design that ignored the pin would accept it. It writes zeros over set lock bits and over the suspend flag: a design without the sticky merge would clear the locks, and one that let the data through would clear the suspend flag. It checks that a refused write still clears the write-enable latch. It checks that a supply cycle releases mode 10 but not mode 11 and keeps complement-protect. A design that reset the wrong fields on a supply cycle would show up here as a lost bit or a stuck lock-down.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    localparam int SR_W     = 16;
    localparam int SEC_REGS = 4;
    localparam int APROT_W  = 5;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_SUSP   = 8'h75;
    localparam logic [7:0] OP_RESUME = 8'h7A;

    typedef enum logic [1:0] {
        SRP_SOFT   = 2'b00,
        SRP_PIN    = 2'b01,
        SRP_SUPPLY = 2'b10,
        SRP_OTP    = 2'b11
    } srp_mode_e;

    // Occupies status bits 14..2, most significant field first.
    typedef struct packed {
        logic                cmp;
        logic [SEC_REGS-1:0] lock;
        logic                spare;
        srp_mode_e           srp;
        logic [APROT_W-1:0]  aprot;
    } nv_bits_t;

    localparam int NV_W  = $bits(nv_bits_t);
    localparam int NV_LO = 2;
    localparam int NV_HI = NV_LO + NV_W - 1;

    function automatic logic mode_allows(input srp_mode_e m, input logic pin_high);
        case (m)
            SRP_SOFT: mode_allows = 1'b1;
            SRP_PIN:  mode_allows = pin_high;
            default:  mode_allows = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sr_mode_arbiter.sv
module sr_mode_arbiter
    import flash_sr_pkg::*;
(
    input  srp_mode_e srp,
    input  logic      pin_high,
    input  logic      wel,
    output logic      wr_ok
);
    always_comb wr_ok = wel & mode_allows(srp, pin_high);
endmodule

// File: rtl/sr_volatile.sv
module sr_volatile
    import flash_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       nv_init,
    input  logic       pwr_cycle,
    input  logic       instr_valid,
    input  logic [7:0] instr_op,
    output logic       wel,
    output logic       sus
);
    always_ff @(posedge clk) begin
        if (rst || nv_init || pwr_cycle) begin
            wel <= 1'b0;
            sus <= 1'b0;
        end else if (instr_valid) begin
            case (instr_op)
                OP_WREN:   wel <= 1'b1;
                OP_WRDI:   wel <= 1'b0;
                OP_WRSR:   wel <= 1'b0;
                OP_SUSP:   sus <= 1'b1;
                OP_RESUME: sus <= 1'b0;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/sr_nv_bank.sv
module sr_nv_bank
    import flash_sr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     nv_init,
    input  logic     pwr_cycle,
    input  logic     wr_accept,
    input  nv_bits_t wr_bits,
    output nv_bits_t nv
);
    logic load_default;
    logic take_write;

    always_comb begin
        load_default = rst | nv_init;
        take_write   = wr_accept & ~pwr_cycle;
    end

    // Lock bits: one-way, one cell per security register.
    for (genvar i = 0; i < SEC_REGS; i++) begin : g_lock
        always_ff @(posedge clk) begin
            if (load_default)
                nv.lock[i] <= 1'b0;
            else if (take_write && wr_bits.lock[i])
                nv.lock[i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (load_default) begin
            nv.cmp   <= 1'b0;
            nv.spare <= 1'b0;
            nv.srp   <= SRP_SOFT;
            nv.aprot <= '0;
        end else if (pwr_cycle) begin
            if (nv.srp == SRP_SUPPLY)
                nv.srp <= SRP_SOFT;
        end else if (take_write) begin
            nv.cmp   <= wr_bits.cmp;
            nv.spare <= wr_bits.spare;
            nv.srp   <= wr_bits.srp;
            nv.aprot <= wr_bits.aprot;
        end
    end
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
    import flash_sr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                instr_valid,
    input  logic [7:0]          instr_op,
    input  logic [SR_W-1:0]     wr_data,
    input  logic                wp_pin_high,
    input  logic                pwr_cycle,
    input  logic                nv_init,
    output logic [SR_W-1:0]     status_o,
    output logic                sr_wr_ok_o,
    output logic [SEC_REGS-1:0] sec_lock_o,
    output logic                cmp_o
);
    nv_bits_t nv;
    nv_bits_t wr_bits;
    logic     wel;
    logic     sus;
    logic     wr_ok;
    logic     wr_accept;

    always_comb begin
        wr_bits   = nv_bits_t'(wr_data[NV_HI:NV_LO]);
        wr_accept = instr_valid && (instr_op == OP_WRSR) && wr_ok;
    end

    sr_mode_arbiter arb_i (
        .srp      (nv.srp),
        .pin_high (wp_pin_high),
        .wel      (wel),
        .wr_ok    (wr_ok)
    );

    sr_volatile vol_i (
        .clk         (clk),
        .rst         (rst),
        .nv_init     (nv_init),
        .pwr_cycle   (pwr_cycle),
        .instr_valid (instr_valid),
        .instr_op    (instr_op),
        .wel         (wel),
        .sus         (sus)
    );

    sr_nv_bank nvb_i (
        .clk       (clk),
        .rst       (rst),
        .nv_init   (nv_init),
        .pwr_cycle (pwr_cycle),
        .wr_accept (wr_accept),
        .wr_bits   (wr_bits),
        .nv        (nv)
    );

    always_comb begin
        status_o   = {sus, nv, wel, 1'b0};
        sr_wr_ok_o = wr_ok;
        sec_lock_o = nv.lock;
        cmp_o      = nv.cmp;
    end
endmodule

// File: rtl/flash_sr_guard_chk.sv
module flash_sr_guard_chk
    import flash_sr_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                instr_valid,
    input logic [7:0]          instr_op,
    input logic [SR_W-1:0]     wr_data,
    input logic                wp_pin_high,
    input logic                pwr_cycle,
    input logic                nv_init,
    input logic [SR_W-1:0]     status_o,
    input logic                sr_wr_ok_o,
    input logic [SEC_REGS-1:0] sec_lock_o,
    input logic                cmp_o
);
    a_r1_bit0_zero: assert property (@(posedge clk) disable iff (rst)
        status_o[0] == 1'b0);

    a_r3_pin_low_blocks: assert property (@(posedge clk) disable iff (rst)
        (status_o[8:7] == 2'b01 && !wp_pin_high) |-> !sr_wr_ok_o);

    a_r4_supply_release: assert property (@(posedge clk) disable iff (rst)
        (pwr_cycle && !nv_init && status_o[8:7] == 2'b10) |=> status_o[8:7] == 2'b00);

    a_r5_otp_frozen: assert property (@(posedge clk) disable iff (rst)
        (status_o[8:7] == 2'b11 && !nv_init) |=> $stable(status_o[14:2]));

    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        !nv_init |=> ((sec_lock_o & $past(sec_lock_o)) == $past(sec_lock_o)));

    a_r8_refused_keeps: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_op == 8'h01 && !sr_wr_ok_o && !nv_init && !pwr_cycle)
        |=> $stable(status_o[14:2]));

    a_r8_wel_dropped: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_op == 8'h01) |=> !status_o[1]);

    a_r9_supply_clears: assert property (@(posedge clk) disable iff (rst)
        pwr_cycle |=> (!status_o[15] && !status_o[1]));

    a_r10_cmp_mirror: assert property (@(posedge clk) disable iff (rst)
        cmp_o == status_o[14]);

    a_r6_lock_mirror: assert property (@(posedge clk) disable iff (rst)
        sec_lock_o == status_o[13:10]);
endmodule

bind flash_sr_guard flash_sr_guard_chk chk_i (.*);

// File: tb/flash_sr_guard_tb_top.sv
module flash_sr_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [7:0]  instr_op = '0;
    logic [15:0] wr_data = '0;
    logic        wp_pin_high = 1'b0;
    logic        pwr_cycle = 1'b0;
    logic        nv_init = 1'b0;
    logic [15:0] status_o;
    logic        sr_wr_ok_o;
    logic [3:0]  sec_lock_o;
    logic        cmp_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    flash_sr_guard dut_i (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_op    (instr_op),
        .wr_data     (wr_data),
        .wp_pin_high (wp_pin_high),
        .pwr_cycle   (pwr_cycle),
        .nv_init     (nv_init),
        .status_o    (status_o),
        .sr_wr_ok_o  (sr_wr_ok_o),
        .sec_lock_o  (sec_lock_o),
        .cmp_o       (cmp_o)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [7:0] op, input logic [15:0] d);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_op    = op;
        wr_data     = d;
        @(negedge clk);
        instr_valid = 1'b0;
        wr_data     = '0;
    endtask

    task automatic supply_cycle();
        @(negedge clk);
        pwr_cycle = 1'b1;
        @(negedge clk);
        pwr_cycle = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status", status_o, 16'h0000);
        check("R1 ok", {15'd0, sr_wr_ok_o}, 16'd0);
        check("R1 locks", {12'd0, sec_lock_o}, 16'd0);
    endtask

    task automatic t_soft_mode();
        wp_pin_high = 1'b0;
        issue(8'h06, 0);
        check("R2 wel set", status_o, 16'h0002);
        check("R2 ok pin low", {15'd0, sr_wr_ok_o}, 16'd1);
        issue(8'h04, 0);
        check("R2 wel clear", status_o, 16'h0000);
        issue(8'h06, 0);
        issue(8'h01, 16'h007C);
        check("R8 accepted write", status_o, 16'h007C);
        check("R8 ok after write", {15'd0, sr_wr_ok_o}, 16'd0);
    endtask

    task automatic t_pin_mode();
        issue(8'h06, 0);
        issue(8'h01, 16'h0080);
        check("R3 enter pin mode", status_o, 16'h0080);
        wp_pin_high = 1'b0;
        issue(8'h06, 0);
        check("R3 pin low ok", {15'd0, sr_wr_ok_o}, 16'd0);
        issue(8'h01, 16'h0000);
        check("R8 refused keeps, wel off", status_o, 16'h0080);
        wp_pin_high = 1'b1;
        issue(8'h06, 0);
        check("R3 pin high ok", {15'd0, sr_wr_ok_o}, 16'd1);
        issue(8'h01, 16'h0000);
        check("R3 pin high write", status_o, 16'h0000);
    endtask

    task automatic t_supply_mode();
        wp_pin_high = 1'b1;
        issue(8'h06, 0);
        issue(8'h01, 16'h4100);
        check("R10 cmp set", {15'd0, cmp_o}, 16'd1);
        issue(8'h06, 0);
        check("R4 ok in lockdown", {15'd0, sr_wr_ok_o}, 16'd0);
        issue(8'h01, 16'h0000);
        check("R4 refused", status_o, 16'h4100);
        supply_cycle();
        check("R4 released, R10 cmp kept", status_o, 16'h4000);
        issue(8'h06, 0);
        issue(8'h01, 16'h0000);
        check("R4 writable after cycle", status_o, 16'h0000);
    endtask

    task automatic t_locks();
        issue(8'h06, 0);
        issue(8'h01, 16'h0800);
        check("R6 lock one", {12'd0, sec_lock_o}, 16'h0002);
        issue(8'h06, 0);
        issue(8'h01, 16'h2000);
        check("R6 lock two", status_o, 16'h2800);
        issue(8'h06, 0);
        issue(8'h01, 16'h0000);
        check("R6 zero no clear", status_o, 16'h2800);
        supply_cycle();
        check("R6 survive cycle", {12'd0, sec_lock_o}, 16'h000A);
    endtask

    task automatic t_suspend();
        issue(8'h75, 0);
        check("R7 set", status_o, 16'hA800);
        issue(8'h06, 0);
        issue(8'h01, 16'h0000);
        check("R7 write ignored", status_o, 16'hA800);
        issue(8'h7A, 0);
        check("R7 resume", status_o, 16'h2800);
        issue(8'h75, 0);
        issue(8'h06, 0);
        supply_cycle();
        check("R9 cycle clears sus wel", status_o, 16'h2800);
    endtask

    task automatic t_otp_mode();
        issue(8'h06, 0);
        issue(8'h01, 16'h0180);
        check("R5 enter otp", status_o, 16'h2980);
        issue(8'h06, 0);
        check("R5 ok", {15'd0, sr_wr_ok_o}, 16'd0);
        issue(8'h01, 16'h0000);
        check("R5 refused", status_o, 16'h2980);
        supply_cycle();
        check("R5 survives cycle", status_o, 16'h2980);
    endtask

    task automatic t_init();
        @(negedge clk);
        nv_init = 1'b1;
        @(negedge clk);
        nv_init = 1'b0;
        check("R1 init defaults", status_o, 16'h0000);
        issue(8'h06, 0);
        check("R1 writable after init", {15'd0, sr_wr_ok_o}, 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_soft_mode();
        t_pin_mode();
        t_supply_mode();
        t_locks();
        t_suspend();
        t_otp_mode();
        t_init();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule